// File: doc/BRIEF.md
# Register-RAM block-copy engine

This block holds a 64-byte register file, arranged as eight banks of eight byte registers, and moves runs of bytes between that file and an external byte-wide data memory. A single start pulse launches a copy. A direction select chooses between two moves. In the first, register entries go out to memory at a write pointer. In the second, memory bytes at a read pointer land in register entries. The register entry is selected by a byte pointer whose low bit is dropped, so that pointer steps by two per byte. A loop counter sets the length of the run.

The loop is a do-while on the counter: the body runs before the counter is tested. A counter of zero at launch therefore wraps and moves 256 bytes. Each beat takes one clock and performs one memory access together with one register-file access. Pointers wrap modulo 256. While the engine is idle, a small host port reads and writes the register file using the same entry selection, so the file can be loaded and inspected.

Top module: `regram_copy_engine`

## Requirements
- R1: After reset, busy, done, mem_we and mem_re are 0, and ix0_out, ix2_out, rxb_out and cnt_out are 0.
- R2: With dir_rd=0, each beat drives mem_we=1 with mem_addr equal to the write pointer and mem_wdata equal to register entry (rxb>>1)&0x3F. The write pointer then increments and the byte pointer adds 2.
- R3: With dir_rd=1, each beat drives mem_re=1 with mem_addr equal to the read pointer and stores mem_rdata (sampled in the same cycle) into register entry (rxb>>1)&0x3F. The read pointer then increments and the byte pointer adds 2.
- R4: A copy makes exactly cnt_init beats, or 256 beats when cnt_init is 0, and cnt_out is 0 when it ends.
- R5: busy is high in every beat cycle and only then. done is high for exactly one cycle, in the cycle after the final beat, with busy low.
- R6: The read pointer, the write pointer and the byte pointer wrap modulo 256. The byte pointer 0xFE plus 2 gives 0x00, which selects entry 0.
- R7: When idle, host_en=1 with host_we=1 writes host_wdata to entry (host_addr>>1)&0x3F. host_en=1 with host_we=0 returns that entry on host_rdata one cycle later. Host addresses 2k and 2k+1 select the same entry.
- R8: While busy, a start pulse and any host access are ignored. The running copy keeps its length and pointers, and the register file is not written by the host.
- R9: After a copy ends, ix0_out, ix2_out, rxb_out and cnt_out hold their final values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a copy when idle |
| dir_rd | input | 1 | 0: register file to memory, 1: memory to register file |
| ix0_init | input | 8 | Initial read pointer |
| ix2_init | input | 8 | Initial write pointer |
| rxb_init | input | 8 | Initial register byte pointer |
| cnt_init | input | 8 | Initial loop count (0 means 256) |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| host_en | input | 1 | Host register-file access enable |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 8 | Host byte pointer |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle end-of-copy pulse |
| ix0_out | output | 8 | Current read pointer |
| ix2_out | output | 8 | Current write pointer |
| rxb_out | output | 8 | Current byte pointer |
| cnt_out | output | 8 | Current loop count |

## Verification
A wrong byte pointer or a wrong bank selection shows up at the ports in the very next outgoing beat as an unexpected mem_wdata. On an inbound copy it shows up only later, when the host reads back the register file. A loop counter that is off shows up as an extra or missing write strobe and a misplaced done pulse at the end of the run. The scoreboard compares every outgoing beat in order, and a full readback after each inbound copy catches a misplaced store. Wrap cases are aimed at the pointers, and the 256-beat run is aimed at the counter.

// File: rtl/regram_copy_engine.sv
module regram_copy_engine #(
  parameter int DATA_W    = 8,
  parameter int PTR_W     = 8,
  parameter int BANKS     = 8,
  parameter int BANK_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_rd,
  input  logic [PTR_W-1:0]  ix0_init,
  input  logic [PTR_W-1:0]  ix2_init,
  input  logic [PTR_W-1:0]  rxb_init,
  input  logic [PTR_W-1:0]  cnt_init,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [PTR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              busy,
  output logic              done,
  output logic [PTR_W-1:0]  ix0_out,
  output logic [PTR_W-1:0]  ix2_out,
  output logic [PTR_W-1:0]  rxb_out,
  output logic [PTR_W-1:0]  cnt_out
);
  localparam int DEPTH = BANKS * BANK_REGS;
  localparam int SEL_W = $clog2(DEPTH);

  logic [DATA_W-1:0] ram [DEPTH];
  logic              dir_q;
  logic [PTR_W-1:0]  ix0_q, ix2_q, rxb_q, cnt_q;
  logic [SEL_W-1:0]  sel, host_sel;

  assign sel      = rxb_q[SEL_W:1];
  assign host_sel = host_addr[SEL_W:1];

  assign mem_addr  = dir_q ? ix0_q : ix2_q;
  assign mem_wdata = ram[sel];
  assign mem_we    = busy & ~dir_q;
  assign mem_re    = busy & dir_q;

  assign ix0_out = ix0_q;
  assign ix2_out = ix2_q;
  assign rxb_out = rxb_q;
  assign cnt_out = cnt_q;

  always_ff @(posedge clk) begin
    if (busy && dir_q)
      ram[sel] <= mem_rdata;
    else if (!busy && host_en && host_we)
      ram[host_sel] <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      dir_q      <= 1'b0;
      ix0_q      <= '0;
      ix2_q      <= '0;
      rxb_q      <= '0;
      cnt_q      <= '0;
      host_rdata <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (host_en && !host_we)
          host_rdata <= ram[host_sel];
        if (start) begin
          busy  <= 1'b1;
          dir_q <= dir_rd;
          ix0_q <= ix0_init;
          ix2_q <= ix2_init;
          rxb_q <= rxb_init;
          cnt_q <= cnt_init;
        end
      end else begin
        rxb_q <= rxb_q + PTR_W'(2);
        cnt_q <= cnt_q - PTR_W'(1);
        if (dir_q) ix0_q <= ix0_q + PTR_W'(1);
        else       ix2_q <= ix2_q + PTR_W'(1);
        if (cnt_q == PTR_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r5_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q == PTR_W'(1)) |=> (done && !busy));
  a_r4_keep_going: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != PTR_W'(1)) |=> busy);
  a_r6_rxb_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> rxb_q == $past(rxb_q) + PTR_W'(2));
  a_r2_write_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !dir_q) |=> ix2_q == $past(ix2_q) + PTR_W'(1));
  a_r3_read_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dir_q) |=> ix0_q == $past(ix0_q) + PTR_W'(1));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(rxb_q) && $stable(cnt_q) && $stable(ix0_q) && $stable(ix2_q)));
endmodule

// File: tb/regram_copy_engine_tb.sv
module regram_copy_engine_tb;
  logic clk = 0, rst_n = 0;
  logic start = 0, dir_rd = 0;
  logic [7:0] ix0_init = 0, ix2_init = 0, rxb_init = 0, cnt_init = 0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, host_rdata;
  logic mem_we, mem_re, busy, done;
  logic host_en = 0, host_we = 0;
  logic [7:0] host_addr = 0, host_wdata = 0;
  logic [7:0] ix0_out, ix2_out, rxb_out, cnt_out;

  logic [7:0]  mem [256];
  logic [7:0]  shadow [64];
  logic [15:0] exp_q [$];
  int checks = 0, errors = 0, beats = 0, cycles = 0;

  always #2 clk = ~clk;
  assign mem_rdata = mem[mem_addr];

  regram_copy_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_rd(dir_rd),
    .ix0_init(ix0_init), .ix2_init(ix2_init), .rxb_init(rxb_init), .cnt_init(cnt_init),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy), .done(done),
    .ix0_out(ix0_out), .ix2_out(ix2_out), .rxb_out(rxb_out), .cnt_out(cnt_out));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      finish_run();
    end
  end

  // monitor: pops expected outgoing beats and applies them to memory
  always @(negedge clk) begin
    if (busy) beats++;
    if (mem_we) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2 unexpected write", {mem_addr, mem_wdata}, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R2 write beat", {mem_addr, mem_wdata}, e);
      end
      mem[mem_addr] = mem_wdata;
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    cyc();
    host_en = 1; host_we = 1; host_addr = a; host_wdata = d;
    shadow[a[6:1]] = d;
    cyc();
    host_en = 0; host_we = 0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [7:0] d);
    cyc();
    host_en = 1; host_we = 0; host_addr = a;
    @(negedge clk); @(negedge clk);
    d = host_rdata;
    host_en = 0;
  endtask

  task automatic launch(input bit dr, input logic [7:0] i0, input logic [7:0] i2,
                        input logic [7:0] rb, input logic [7:0] n);
    int total;
    logic [7:0] p0, p2, pb;
    total = (n == 0) ? 256 : n;
    p0 = i0; p2 = i2; pb = rb;
    for (int k = 0; k < total; k++) begin
      if (!dr) begin
        exp_q.push_back({p2, shadow[pb[6:1]]});
        p2 = p2 + 8'd1;
      end else begin
        shadow[pb[6:1]] = mem[p0];
        p0 = p0 + 8'd1;
      end
      pb = pb + 8'd2;
    end
    cyc();
    start = 1; dir_rd = dr; ix0_init = i0; ix2_init = i2; rxb_init = rb; cnt_init = n;
    beats = 0;
    cyc();
    start = 0;
  endtask

  task automatic wait_done(input int exp_beats, input logic [7:0] e0, input logic [7:0] e2,
                           input logic [7:0] eb, input string tag);
    int guard = 0;
    @(negedge clk);
    while (!done && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    chk(done && !busy, {tag, " R5 done with busy low"}, {done, busy}, 2);
    chk(beats == exp_beats, {tag, " R4 beat count"}, beats, exp_beats);
    chk(exp_q.size() == 0, {tag, " R2 all beats seen"}, exp_q.size(), 0);
    chk(ix0_out == e0 && ix2_out == e2, {tag, " R6 pointers"}, {ix0_out, ix2_out}, {e0, e2});
    chk(rxb_out == eb && cnt_out == 0, {tag, " R6 byte pointer/count"}, {rxb_out, cnt_out}, {eb, 8'd0});
    @(negedge clk);
    chk(!done && !busy, {tag, " R5 done single cycle"}, {done, busy}, 0);
  endtask

  task automatic verify_regs(input string tag);
    logic [7:0] d;
    for (int k = 0; k < 64; k++) begin
      host_read(8'(k * 2), d);
      if (d != shadow[k]) chk(0, {tag, " R3 register readback"}, d, shadow[k]);
    end
    chk(1, {tag, " R3 register readback complete"}, 0, 0);
  endtask

  initial begin
    logic [7:0] d;
    for (int k = 0; k < 256; k++) mem[k] = 8'(k * 7 + 3);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_we && !mem_re, "R1 idle flags", {busy, done, mem_we, mem_re}, 0);
    chk(ix0_out == 0 && ix2_out == 0 && rxb_out == 0 && cnt_out == 0, "R1 registers",
        {ix0_out, ix2_out, rxb_out, cnt_out}, 0);
    rst_n = 1;

    for (int k = 0; k < 64; k++) host_write(8'(k * 2), 8'(k ^ 8'hA5));

    // R7 odd/even alias
    host_write(8'h07, 8'h5C);
    host_read(8'h06, d);
    chk(d == 8'h5C, "R7 alias even/odd", d, 8'h5C);

    // R2 outbound copy
    launch(0, 8'h00, 8'h20, 8'h10, 8'd4);
    wait_done(4, 8'h00, 8'h24, 8'h18, "outbound");

    // R3 inbound copy from odd byte pointer
    launch(1, 8'h40, 8'h00, 8'h21, 8'd3);
    wait_done(3, 8'h43, 8'h00, 8'h27, "inbound");
    verify_regs("inbound");

    // R4 R6 count zero means 256 beats, full wrap
    launch(0, 8'h00, 8'hF0, 8'h05, 8'd0);
    wait_done(256, 8'h00, 8'hF0, 8'h05, "count0");

    // R6 inbound wrap of read and byte pointers
    launch(1, 8'hFE, 8'h00, 8'hFC, 8'd3);
    wait_done(3, 8'h01, 8'h00, 8'h02, "wrap");
    verify_regs("wrap");

    // R8 start and host write while busy are ignored
    launch(0, 8'h00, 8'h80, 8'h30, 8'd5);
    cyc();
    start = 1; dir_rd = 1; ix0_init = 8'h11; ix2_init = 8'h22; rxb_init = 8'h33; cnt_init = 8'd9;
    host_en = 1; host_we = 1; host_addr = 8'h02; host_wdata = 8'hEE;
    cyc();
    start = 0; host_en = 0; host_we = 0;
    wait_done(5, 8'h00, 8'h85, 8'h3A, "busy-ignore R8");
    host_read(8'h02, d);
    chk(d == shadow[1], "R8 host write during copy ignored", d, shadow[1]);

    // R9 hold after done
    repeat (4) cyc();
    @(negedge clk);
    chk(ix2_out == 8'h85 && rxb_out == 8'h3A && cnt_out == 0 && !busy, "R9 hold",
        {ix2_out, rxb_out, cnt_out}, {8'h85, 8'h3A, 8'h00});

    finish_run();
  end
endmodule